// File: doc/BRIEF.md
# Real-Time Clock Counter with Time-of-Day and Sub-Second Alarms

This block is the counting core of a real-time clock. It runs on the slow clock domain and receives a 4096 Hz tick enable. A prescaler divides the tick down so that an 8-bit fraction-of-a-second counter advances at 256 Hz. Each time the fraction counter wraps, a 32-bit seconds counter increments. Two alarms are built on the counters. The time-of-day alarm compares the low bits of the seconds counter with a programmed value. The sub-second alarm is a free-running up-counter that counts ticks from a programmed reload value and raises its flag each time it overflows.

Software reaches the block through a word-indexed register bus with a single-cycle write strobe and a combinational read. The run bit and the two alarm enables are protected by a write-unlock bit and a busy window. A write to these bits is taken only when the unlock bit is already set and busy is clear. A write that is taken opens a busy window of a fixed number of clock cycles, and the new values become active only when that window closes. A ready flag reports that the counters have just moved. The flag falls one tick before each update of the fraction counter and rises again on the update. The single interrupt line combines the ready flag and the two alarm flags, each gated by its own enable.

Top module: `rtc_core`

## Requirements
- R1: While the run bit is active, the fraction counter (address 1, bits 7:0) advances by one on every TICKS_PER_SUB-th tick. While the run bit is inactive, neither counter moves.
- R2: The seconds counter (address 0) increments on the same update in which the fraction counter wraps from 0xFF to 0x00.
- R3: In the control word (address 4), bit 0 is run, bit 1 is the time-of-day alarm enable and bit 2 is the sub-second alarm enable. A write to these bits is accepted only when the unlock bit is 1 and busy is 0, both as they stood before the write. An accepted value becomes active in the cycle in which busy falls. A write that is not accepted leaves them unchanged.
- R4: Control bit 3 (busy) is read-only. It reads 1 for BUSY_CYCLES cycles after an accepted write and for BUSY_CYCLES cycles after reset, so the control word reads 0x00000008 out of reset.
- R5: Control bit 6 (time-of-day flag) is set while running with bit 1 active and the low 20 bits of the seconds counter equal to the alarm value (address 2). An accepted write with bit 1 = 0 clears the flag.
- R6: The sub-second alarm counter is loaded from the reload value (address 3) when the reload value is written and when busy falls. It counts ticks while running with bit 2 active. When it overflows it sets control bit 7 and reloads. An accepted write with bit 2 = 0 clears bit 7.
- R7: Control bit 4 (ready) is cleared on the tick one before each fraction-counter update and set on the update. Any control write with bit 4 = 0 clears it, and writing 1 has no effect.
- R8: The unlock bit (control bit 15) and the ready interrupt enable (bit 5) follow every control write. Writes to addresses 0 and 1 are accepted only when the unlock bit is 1 and busy is 0.
- R9: irq is high when (bit 6 and active bit 1) or (bit 7 and active bit 2) or (bit 4 and bit 5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow-domain clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickEn | input | 1 | 4096 Hz tick enable |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 3 | Register word index |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr |
| irq | output | 1 | Combined interrupt |

## Verification
The bench drives the tick in three patterns: absent, on every cycle and on every third cycle. Each pattern places the ready-flag drop and rise and the prescaler wrap at different distances from the bus writes. Guarded writes are issued with the unlock bit clear, during the busy window and in the legal case. This separates acceptance from the deferred activation that follows when busy falls. The seconds and reload values are preloaded near their boundaries, which makes the fraction wrap, the time-of-day match and the sub-second overflow-and-reload happen within a short run. Clearing the enables then shows the flags falling and the irq terms dropping out one by one.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  // register word indices
  localparam int ADR_SEC    = 0;
  localparam int ADR_SUB    = 1;
  localparam int ADR_TOD    = 2;
  localparam int ADR_RELOAD = 3;
  localparam int ADR_CTRL   = 4;

  // strobes from control to datapath
  typedef struct packed {
    logic run;
    logic todOn;
    logic ssOn;
    logic arm;       // busy window closing: reload the sub-second counter
    logic ldSec;
    logic ldSub;
    logic ldTod;
    logic ldReload;
  } dpCtl_t;
endpackage

// File: rtl/rtc_datapath.sv
module rtc_datapath import rtc_pkg::*; #(
  parameter int SEC_W         = 32,
  parameter int SUB_W         = 8,
  parameter int TOD_W         = 20,
  parameter int SS_W          = 32,
  parameter int TICKS_PER_SUB = 16,
  parameter int DATA_W        = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  dpCtl_t            ctl,
  input  logic [DATA_W-1:0] wrData,
  output logic [SEC_W-1:0]  sec,
  output logic [SUB_W-1:0]  sub,
  output logic [TOD_W-1:0]  tod,
  output logic [SS_W-1:0]   reload,
  output logic              upd,
  output logic              preUpd,
  output logic              todHit,
  output logic              ssOvf
);
  localparam int PRE_W = $clog2(TICKS_PER_SUB);

  logic [PRE_W-1:0] pre;
  logic [SS_W-1:0]  ssCnt;
  logic             stepRun, ssStep;

  assign stepRun = tickEn && ctl.run;
  assign upd     = stepRun && (pre == PRE_W'(TICKS_PER_SUB - 1));
  assign preUpd  = stepRun && (pre == PRE_W'(TICKS_PER_SUB - 2));
  assign ssStep  = tickEn && ctl.run && ctl.ssOn;
  assign ssOvf   = ssStep && (&ssCnt) && !ctl.arm && !ctl.ldReload;
  assign todHit  = ctl.run && ctl.todOn && (sec[TOD_W-1:0] == tod);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pre    <= '0;
      sub    <= '0;
      sec    <= '0;
      tod    <= '0;
      reload <= '0;
      ssCnt  <= '0;
    end else begin
      if (stepRun) pre <= upd ? '0 : pre + PRE_W'(1);

      if (ctl.ldSub)    sub <= wrData[SUB_W-1:0];
      else if (upd)     sub <= sub + SUB_W'(1);

      if (ctl.ldSec)            sec <= wrData[SEC_W-1:0];
      else if (upd && (&sub))   sec <= sec + SEC_W'(1);

      if (ctl.ldTod)    tod    <= wrData[TOD_W-1:0];
      if (ctl.ldReload) reload <= wrData[SS_W-1:0];

      if (ctl.arm)           ssCnt <= reload;
      else if (ctl.ldReload) ssCnt <= wrData[SS_W-1:0];
      else if (ssStep)       ssCnt <= (&ssCnt) ? reload : ssCnt + SS_W'(1);
    end
  end

  // R1: counters frozen while stopped and not loaded
  p_sub_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.run && !ctl.ldSub) |=> $stable(sub));
  // R2: fraction wrap carries into seconds
  p_sec_carry_r2: assert property (@(posedge clk) disable iff (!rstN)
    (upd && (&sub) && !ctl.ldSec) |=> (sec == $past(sec) + SEC_W'(1)));
  // R6: overflow reloads the alarm counter
  p_ss_reload_r6: assert property (@(posedge clk) disable iff (!rstN)
    ssOvf |=> (ssCnt == $past(reload)));
endmodule

// File: rtl/rtc_ctrl.sv
module rtc_ctrl import rtc_pkg::*; #(
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 32,
  parameter int BUSY_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              upd,
  input  logic              preUpd,
  input  logic              todHit,
  input  logic              ssOvf,
  output dpCtl_t            ctl,
  output logic [DATA_W-1:0] ctrlWord,
  output logic              irq
);
  localparam int BC_W = $clog2(BUSY_CYCLES + 1);

  logic [BC_W-1:0] busyCnt;
  logic [2:0]      pend;
  logic            enAct, todAct, ssAct;
  logic            todFlag, ssFlag, ready, readyIe, weBit;
  logic            busy, guard, wrCtrl, accept, arm;
  logic            unusedData;

  assign unusedData = ^busWrData;
  assign busy   = (busyCnt != '0);
  assign guard  = weBit && !busy;
  assign wrCtrl = busWr && (busAddr == ADDR_W'(ADR_CTRL));
  assign accept = wrCtrl && guard;
  assign arm    = (busyCnt == BC_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyCnt <= BC_W'(BUSY_CYCLES);
      pend    <= '0;
      enAct   <= 1'b0;
      todAct  <= 1'b0;
      ssAct   <= 1'b0;
      todFlag <= 1'b0;
      ssFlag  <= 1'b0;
      ready   <= 1'b0;
      readyIe <= 1'b0;
      weBit   <= 1'b0;
    end else begin
      if (accept)    busyCnt <= BC_W'(BUSY_CYCLES);
      else if (busy) busyCnt <= busyCnt - BC_W'(1);

      if (accept) pend <= busWrData[2:0];
      if (arm) {ssAct, todAct, enAct} <= pend;

      if (wrCtrl) begin
        weBit   <= busWrData[15];
        readyIe <= busWrData[5];
      end

      if (todHit)                         todFlag <= 1'b1;
      else if (accept && !busWrData[1])   todFlag <= 1'b0;

      if (ssOvf)                          ssFlag <= 1'b1;
      else if (accept && !busWrData[2])   ssFlag <= 1'b0;

      if (upd)                            ready <= 1'b1;
      else if (preUpd)                    ready <= 1'b0;
      else if (wrCtrl && !busWrData[4])   ready <= 1'b0;
    end
  end

  always_comb begin
    ctl.run      = enAct;
    ctl.todOn    = todAct;
    ctl.ssOn     = ssAct;
    ctl.arm      = arm;
    ctl.ldSec    = busWr && (busAddr == ADDR_W'(ADR_SEC)) && guard;
    ctl.ldSub    = busWr && (busAddr == ADDR_W'(ADR_SUB)) && guard;
    ctl.ldTod    = busWr && (busAddr == ADDR_W'(ADR_TOD));
    ctl.ldReload = busWr && (busAddr == ADDR_W'(ADR_RELOAD));
  end

  always_comb begin
    ctrlWord     = '0;
    ctrlWord[0]  = enAct;
    ctrlWord[1]  = todAct;
    ctrlWord[2]  = ssAct;
    ctrlWord[3]  = busy;
    ctrlWord[4]  = ready;
    ctrlWord[5]  = readyIe;
    ctrlWord[6]  = todFlag;
    ctrlWord[7]  = ssFlag;
    ctrlWord[15] = weBit;
  end

  assign irq = (todFlag && todAct) || (ssFlag && ssAct) || (ready && readyIe);

  // R4: an accepted write opens the busy window
  p_accept_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> busy);
  // R3: active run bit changes only when the window closes
  p_run_deferred_r3: assert property (@(posedge clk) disable iff (!rstN)
    !arm |=> $stable(enAct));
  // R7: ready drops on the tick before an update
  p_ready_drop_r7: assert property (@(posedge clk) disable iff (!rstN)
    preUpd |=> !ready);
  // R5: a match sets the time-of-day flag
  p_tod_flag_r5: assert property (@(posedge clk) disable iff (!rstN)
    todHit |=> todFlag);
endmodule

// File: rtl/rtc_core.sv
module rtc_core import rtc_pkg::*; #(
  parameter int ADDR_W        = 3,
  parameter int DATA_W        = 32,
  parameter int SEC_W         = 32,
  parameter int SUB_W         = 8,
  parameter int TOD_W         = 20,
  parameter int SS_W          = 32,
  parameter int TICKS_PER_SUB = 16,
  parameter int BUSY_CYCLES   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              irq
);
  dpCtl_t             ctl;
  logic [SEC_W-1:0]   sec;
  logic [SUB_W-1:0]   sub;
  logic [TOD_W-1:0]   tod;
  logic [SS_W-1:0]    reload;
  logic [DATA_W-1:0]  ctrlWord;
  logic               upd, preUpd, todHit, ssOvf;

  rtc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUSY_CYCLES(BUSY_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr), .busWrData(busWrData),
    .upd(upd), .preUpd(preUpd), .todHit(todHit), .ssOvf(ssOvf),
    .ctl(ctl), .ctrlWord(ctrlWord), .irq(irq));

  rtc_datapath #(.SEC_W(SEC_W), .SUB_W(SUB_W), .TOD_W(TOD_W), .SS_W(SS_W),
                 .TICKS_PER_SUB(TICKS_PER_SUB), .DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .ctl(ctl), .wrData(busWrData),
    .sec(sec), .sub(sub), .tod(tod), .reload(reload),
    .upd(upd), .preUpd(preUpd), .todHit(todHit), .ssOvf(ssOvf));

  always_comb begin
    case (busAddr)
      ADDR_W'(ADR_SEC):    busRdData = DATA_W'(sec);
      ADDR_W'(ADR_SUB):    busRdData = DATA_W'(sub);
      ADDR_W'(ADR_TOD):    busRdData = DATA_W'(tod);
      ADDR_W'(ADR_RELOAD): busRdData = DATA_W'(reload);
      ADDR_W'(ADR_CTRL):   busRdData = ctrlWord;
      default:             busRdData = '0;
    endcase
  end
endmodule

// File: tb/tb_rtc_core.sv
module tb_rtc_core;
  localparam int TPS = 4;
  localparam int BSY = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        busWr = 1'b0;
  logic [2:0]  busAddr = 3'd0;
  logic [31:0] busWrData = 32'd0;
  logic [31:0] busRdData;
  logic        irq;

  int vectors = 0;
  int errors = 0;
  int cyc = 0;
  int tickMode = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rtc_core #(.TICKS_PER_SUB(TPS), .BUSY_CYCLES(BSY)) dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busWr(busWr), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .irq(irq));

  // behavioural reference model
  logic [31:0] mSec, mRel, mSsc;
  logic [7:0]  mSub;
  logic [19:0] mTod;
  int          mPre, mBcnt;
  logic [2:0]  mPend;
  bit mEn, mTodE, mSsE, mTodF, mSsF, mRdy, mRie, mWe;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mSec = 0; mRel = 0; mSsc = 0; mSub = 0; mTod = 0; mPre = 0; mBcnt = BSY;
      mPend = 0; mEn = 0; mTodE = 0; mSsE = 0; mTodF = 0; mSsF = 0;
      mRdy = 0; mRie = 0; mWe = 0;
    end else begin
      bit g, wc, tr, up, pu, th, ov, arm;
      logic [31:0] nSec, nRel, nSsc; logic [7:0] nSub; logic [19:0] nTod;
      int nPre, nB; logic [2:0] nPend;
      bit nEn, nTodE, nSsE, nTodF, nSsF, nRdy, nRie, nWe;
      g   = mWe && (mBcnt == 0);
      wc  = busWr && busAddr == 4;
      tr  = tickEn && mEn;
      up  = tr && mPre == TPS - 1;
      pu  = tr && mPre == TPS - 2;
      arm = mBcnt == 1;
      th  = mEn && mTodE && mSec[19:0] == mTod;
      ov  = tickEn && mEn && mSsE && mSsc == 32'hFFFF_FFFF && !arm && !(busWr && busAddr == 3);
      nSec = mSec; nSub = mSub; nPre = mPre; nTod = mTod; nRel = mRel; nSsc = mSsc;
      nB = mBcnt; nPend = mPend; nEn = mEn; nTodE = mTodE; nSsE = mSsE;
      nTodF = mTodF; nSsF = mSsF; nRdy = mRdy; nRie = mRie; nWe = mWe;
      if (tr) nPre = (mPre == TPS - 1) ? 0 : mPre + 1;
      if (busWr && busAddr == 1 && g) nSub = busWrData[7:0]; else if (up) nSub = mSub + 1;
      if (busWr && busAddr == 0 && g) nSec = busWrData;
      else if (up && mSub == 8'hFF) nSec = mSec + 1;
      if (busWr && busAddr == 2) nTod = busWrData[19:0];
      if (busWr && busAddr == 3) nRel = busWrData;
      if (arm) nSsc = mRel;
      else if (busWr && busAddr == 3) nSsc = busWrData;
      else if (tickEn && mEn && mSsE) nSsc = (mSsc == 32'hFFFF_FFFF) ? mRel : mSsc + 1;
      if (wc && g) begin nB = BSY; nPend = busWrData[2:0]; end
      else if (mBcnt != 0) nB = mBcnt - 1;
      if (arm) begin nEn = mPend[0]; nTodE = mPend[1]; nSsE = mPend[2]; end
      if (wc) begin nWe = busWrData[15]; nRie = busWrData[5]; end
      if (th) nTodF = 1; else if (wc && g && !busWrData[1]) nTodF = 0;
      if (ov) nSsF = 1; else if (wc && g && !busWrData[2]) nSsF = 0;
      if (up) nRdy = 1; else if (pu) nRdy = 0; else if (wc && !busWrData[4]) nRdy = 0;
      mSec = nSec; mSub = nSub; mPre = nPre; mTod = nTod; mRel = nRel; mSsc = nSsc;
      mBcnt = nB; mPend = nPend; mEn = nEn; mTodE = nTodE; mSsE = nSsE;
      mTodF = nTodF; mSsF = nSsF; mRdy = nRdy; mRie = nRie; mWe = nWe;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d addr %0d: got %h expected %h", tag, cyc, busAddr, act, exp);
    end
  endtask

  task automatic compare();
    case (busAddr)
      3'd0: chk("R2 seconds", busRdData, mSec);
      3'd1: chk("R1 fraction", busRdData, {24'd0, mSub});
      3'd2: chk("R5 alarm value", busRdData, {12'd0, mTod});
      3'd3: chk("R6 reload value", busRdData, mRel);
      3'd4: begin
        chk("R3 enables", {29'd0, busRdData[2:0]}, {29'd0, mSsE, mTodE, mEn});
        chk("R4 busy", {31'd0, busRdData[3]}, {31'd0, mBcnt != 0});
        chk("R7 ready", {31'd0, busRdData[4]}, {31'd0, mRdy});
        chk("R8 unlock and ready-irq enable", {30'd0, busRdData[15], busRdData[5]}, {30'd0, mWe, mRie});
        chk("R5 tod flag", {31'd0, busRdData[6]}, {31'd0, mTodF});
        chk("R6 ss flag", {31'd0, busRdData[7]}, {31'd0, mSsF});
        chk("R4 unused bits zero", {busRdData[31:16], busRdData[14:8]}, 32'd0);
      end
      default: chk("R4 unmapped", busRdData, 32'd0);
    endcase
    chk("R9 irq", {31'd0, irq},
        {31'd0, (mTodF && mTodE) || (mSsF && mSsE) || (mRdy && mRie)});
  endtask

  // one cycle: compare settled outputs, then drive next inputs
  task automatic step(input bit wr, input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cyc++;
    compare();
    busWr = wr;
    busAddr = wr ? a : 3'((cyc % 5));
    busWrData = d;
    tickEn = (tickMode == 1) ? 1'b1 : (tickMode == 3) ? (cyc % 3 == 0) : 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 3'd0, 32'd0);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    step(1, a, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    // R4: reset state, busy high
    @(negedge clk); @(negedge clk);
    busAddr = 3'd4;
    @(negedge clk);
    chk("R4 reset control word", busRdData, 32'h0000_0008);
    rstN = 1'b1;
    idle(6);
    wr(3'd4, 32'h0000_8000);   // R3: unlock was 0, not accepted, sets unlock (R8)
    idle(3);
    wr(3'd4, 32'h0000_8007);   // R3: accepted
    wr(3'd4, 32'h0000_8000);   // R3: rejected, busy
    wr(3'd0, 32'd123);         // R8: rejected, busy
    idle(5);
    tickMode = 1;
    idle(1100);                // R1, R2, R7: fraction wraps
    wr(3'd0, 32'd5);
    wr(3'd2, 32'd6);
    wr(3'd1, 32'h0000_00F0);
    idle(100);                 // R5: seconds reaches alarm
    wr(3'd3, 32'hFFFF_FFF0);   // R6: overflow soon
    idle(30);
    wr(3'd4, 32'h0000_8025);   // R5/R9: tod off clears flag, ready irq on
    tickMode = 3;
    idle(200);
    wr(3'd4, 32'h0000_0001);   // R6: ss off clears flag, unlock dropped
    idle(10);
    wr(3'd0, 32'd99);          // R8: rejected, locked
    wr(3'd1, 32'd7);           // R8: rejected, locked
    idle(10);
    wr(3'd4, 32'h0000_8010);   // R7: writing 1 to ready has no effect
    idle(4);
    wr(3'd4, 32'h0000_8000);   // R3: stop accepted
    idle(10);
    idle(60);                  // R1: counters hold while stopped
    tickMode = 0;
    idle(5);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule